// File: doc/BRIEF.md
# Receive Word Pattern Match Detector

This block sits beside a serial receiver and inspects every word that receiver delivers. Each valid word is compared against two programmable patterns, called pattern A and pattern B, and a three-bit mode input picks the condition that must hold inside the current frame. When the condition holds, a sticky match flag rises. Software or a neighbouring control block clears the flag with a write-one strobe.

The mode field supports several kinds of match. One kind checks only the opening word of a frame, and another checks any word in the frame. A word can be tested against either pattern. Two consecutive words can be tested as an ordered pair, with A first and B second. A masked test is also available, in which pattern B selects the bits that count. A frame-start input marks the boundary between frames. It restarts the word position and drops any half-finished ordered pair. The word width is a parameter, and the masked comparators can be removed at elaboration time.

Top module: `rxm_detect`

## Requirements
- R1: Mode codes 0 and 1 never set the match flag, whatever the received words are.
- R2: Mode code 2 sets the flag when the first word of a frame equals pattern A or pattern B. Later words in the frame have no effect.
- R3: Mode code 3 sets the flag when any word of the frame equals pattern A or pattern B.
- R4: Mode code 4 sets the flag only when the first word of a frame equals pattern A and the second word equals pattern B.
- R5: Mode code 5 sets the flag when some word equals pattern A and the next received word of the same frame equals pattern B. Valid-low cycles between the two words do not break the pair.
- R6: Mode code 6 sets the flag when the first word of a frame, masked with pattern B, equals pattern A masked with pattern B (bitwise AND).
- R7: Mode code 7 applies the masked test of R6 to any word of the frame.
- R8: A frame-start pulse resets the word position and forgets a pending pattern-A word. If frame start and word valid arrive in the same cycle, that word is the first word of the new frame.
- R9: Once set, the flag stays high until a cycle with the clear strobe high. The flag is low in the cycle after that strobe, unless R10 applies.
- R10: If a match and a clear strobe occur in the same cycle, the flag is high afterwards.
- R11: The flag is low after reset. It rises in the cycle after the clock edge that samples the matching valid word, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_word_i | input | WORD_W | Received word |
| rx_valid_i | input | 1 | Qualifies rx_word_i for one cycle |
| frame_start_i | input | 1 | Marks the start of a new frame |
| mode_i | input | 3 | Match mode code (0 to 7) |
| pat_a_i | input | WORD_W | Pattern A |
| pat_b_i | input | WORD_W | Pattern B, also the mask in codes 6 and 7 |
| flag_clr_i | input | 1 | Write-one clear for the match flag |
| match_o | output | 1 | Sticky match flag |

## Verification
Each mode is driven with frames whose matching word sits at different positions: first, second, and later. This separates the first-word modes from the any-word modes. The ordered-pair modes receive both the correct order and reversed or split pairs, and one pair is broken by a frame start, which isolates the position and pending-word logic. The masked modes use words that differ from pattern A only in bits outside the mask, plus one word that differs inside it. A clear strobe that coincides with a match shows which of the two wins.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

   localparam int RXM_MODE_W = 3;

   typedef enum logic [RXM_MODE_W-1:0] {
      RXM_OFF          = 3'd0,
      RXM_RSVD         = 3'd1,
      RXM_FIRST_EITHER = 3'd2,
      RXM_ANY_EITHER   = 3'd3,
      RXM_FIRST_PAIR   = 3'd4,
      RXM_ANY_PAIR     = 3'd5,
      RXM_FIRST_MASKED = 3'd6,
      RXM_ANY_MASKED   = 3'd7
   } rxm_mode_e;

   typedef struct packed {
      logic eq_a;
      logic eq_b;
      logic eq_masked;
   } rxm_cmp_t;

   typedef struct packed {
      logic first;
      logic second;
      logic prev_a;
   } rxm_pos_t;

endpackage

// File: rtl/rxm_compare.sv
module rxm_compare
   import rxm_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter bit MASKED_EN = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [WORD_W-1:0] pat_a_i,
   input  logic [WORD_W-1:0] pat_b_i,
   output rxm_cmp_t          cmp_o
);

   if (WORD_W < 1) begin : g_bad_width
      $error("rxm_compare: WORD_W must be at least 1");
   end

   logic masked_hit;

   if (MASKED_EN) begin : g_masked
      logic [WORD_W-1:0] diff;
      // A bit counts only where pattern B holds a one.
      assign diff       = (word_i ^ pat_a_i) & pat_b_i;
      assign masked_hit = (diff == '0);
   end else begin : g_no_masked
      assign masked_hit = 1'b0;
   end

   always_comb begin
      cmp_o.eq_a      = (word_i == pat_a_i);
      cmp_o.eq_b      = (word_i == pat_b_i);
      cmp_o.eq_masked = masked_hit;
   end

endmodule

// File: rtl/rxm_position.sv
module rxm_position
   import rxm_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     valid_i,
   input  logic     frame_start_i,
   input  logic     eq_a_i,
   output rxm_pos_t pos_o
);

   // Position only needs to tell first, second and later words apart.
   localparam int POS_W   = 2;
   localparam logic [POS_W-1:0] POS_LATE = POS_W'(2);

   logic [POS_W-1:0] cnt_q;
   logic [POS_W-1:0] cnt_eff;
   logic             prev_q;
   logic             prev_eff;

   always_comb begin
      cnt_eff      = frame_start_i ? '0 : cnt_q;
      prev_eff     = frame_start_i ? 1'b0 : prev_q;
      pos_o.first  = (cnt_eff == POS_W'(0));
      pos_o.second = (cnt_eff == POS_W'(1));
      pos_o.prev_a = prev_eff;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         prev_q <= 1'b0;
      end else if (valid_i) begin
         cnt_q  <= (cnt_eff == POS_LATE) ? POS_LATE : cnt_eff + POS_W'(1);
         prev_q <= eq_a_i;
      end else if (frame_start_i) begin
         cnt_q  <= '0;
         prev_q <= 1'b0;
      end
   end

endmodule

// File: rtl/rxm_select.sv
module rxm_select
   import rxm_pkg::*;
(
   input  logic [RXM_MODE_W-1:0] mode_i,
   input  logic                  valid_i,
   input  rxm_cmp_t              cmp_i,
   input  rxm_pos_t              pos_i,
   output logic                  hit_o
);

   rxm_mode_e mode;
   logic      cond;

   always_comb begin
      mode = rxm_mode_e'(mode_i);
      unique case (mode)
         RXM_FIRST_EITHER: cond = pos_i.first & (cmp_i.eq_a | cmp_i.eq_b);
         RXM_ANY_EITHER:   cond = cmp_i.eq_a | cmp_i.eq_b;
         RXM_FIRST_PAIR:   cond = pos_i.second & pos_i.prev_a & cmp_i.eq_b;
         RXM_ANY_PAIR:     cond = pos_i.prev_a & cmp_i.eq_b;
         RXM_FIRST_MASKED: cond = pos_i.first & cmp_i.eq_masked;
         RXM_ANY_MASKED:   cond = cmp_i.eq_masked;
         default:          cond = 1'b0;
      endcase
      hit_o = valid_i & cond;
   end

endmodule

// File: rtl/rxm_flag.sv
module rxm_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   // A set arriving with a clear wins.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= set_i | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/rxm_detect.sv
module rxm_detect
   import rxm_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter bit MASKED_EN = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [WORD_W-1:0]     rx_word_i,
   input  logic                  rx_valid_i,
   input  logic                  frame_start_i,
   input  logic [RXM_MODE_W-1:0] mode_i,
   input  logic [WORD_W-1:0]     pat_a_i,
   input  logic [WORD_W-1:0]     pat_b_i,
   input  logic                  flag_clr_i,
   output logic                  match_o
);

   rxm_cmp_t cmp;
   rxm_pos_t pos;
   logic     hit;

   rxm_compare #(.WORD_W(WORD_W), .MASKED_EN(MASKED_EN)) u_cmp (
      .word_i  (rx_word_i),
      .pat_a_i (pat_a_i),
      .pat_b_i (pat_b_i),
      .cmp_o   (cmp)
   );

   rxm_position u_pos (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .valid_i       (rx_valid_i),
      .frame_start_i (frame_start_i),
      .eq_a_i        (cmp.eq_a),
      .pos_o         (pos)
   );

   rxm_select u_sel (
      .mode_i  (mode_i),
      .valid_i (rx_valid_i),
      .cmp_i   (cmp),
      .pos_i   (pos),
      .hit_o   (hit)
   );

   rxm_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (hit),
      .clr_i  (flag_clr_i),
      .flag_o (match_o)
   );

endmodule

// File: rtl/rxm_detect_chk.sv
module rxm_detect_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [WORD_W-1:0] rx_word_i,
   input logic              rx_valid_i,
   input logic              frame_start_i,
   input logic [2:0]        mode_i,
   input logic [WORD_W-1:0] pat_a_i,
   input logic [WORD_W-1:0] pat_b_i,
   input logic              flag_clr_i,
   input logic              match_o
);

   assert_off_modes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!match_o && (mode_i == 3'd0 || mode_i == 3'd1)) |=> !match_o);

   assert_first_either_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_i && frame_start_i && mode_i == 3'd2 &&
       (rx_word_i == pat_a_i || rx_word_i == pat_b_i)) |=> match_o);

   assert_any_either_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_i && mode_i == 3'd3 &&
       (rx_word_i == pat_a_i || rx_word_i == pat_b_i)) |=> match_o);

   assert_any_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_i && mode_i == 3'd7 &&
       ((rx_word_i & pat_b_i) == (pat_a_i & pat_b_i))) |=> match_o);

   assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o && !flag_clr_i) |=> match_o);

   assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o && flag_clr_i && !rx_valid_i) |=> !match_o);

   assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i && rx_valid_i && mode_i == 3'd3 && rx_word_i == pat_a_i) |=> match_o);

   assert_rise_after_word_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(match_o) |-> $past(rx_valid_i));

endmodule

bind rxm_detect rxm_detect_chk #(.WORD_W(WORD_W)) u_rxm_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .rx_word_i     (rx_word_i),
   .rx_valid_i    (rx_valid_i),
   .frame_start_i (frame_start_i),
   .mode_i        (mode_i),
   .pat_a_i       (pat_a_i),
   .pat_b_i       (pat_b_i),
   .flag_clr_i    (flag_clr_i),
   .match_o       (match_o)
);

// File: tb/rxm_detect_tb.sv
`timescale 1ns/1ps
module rxm_detect_tb_top;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] word = '0;
   logic         valid = 1'b0;
   logic         sof = 1'b0;
   logic [2:0]   mode = 3'd0;
   logic [W-1:0] pa = '0;
   logic [W-1:0] pb = '0;
   logic         clr = 1'b0;
   logic         match;

   int    checks = 0;
   int    fails = 0;
   bit    done = 1'b0;
   string cur_req = "R11";

   always #10 clk = ~clk;

   rxm_detect #(.WORD_W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .rx_word_i(word), .rx_valid_i(valid),
      .frame_start_i(sof), .mode_i(mode), .pat_a_i(pa), .pat_b_i(pb),
      .flag_clr_i(clr), .match_o(match)
   );

   // Behavioural reference: remembers the words of the frame and the flag.
   logic [W-1:0] hist[$];
   int           nwords = 0;
   bit           mflag = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      bit hit;
      hit = 1'b0;
      if (!rst_n) begin
         mflag = 1'b0; nwords = 0; hist.delete();
      end else begin
         if (valid) begin
            if (sof) begin nwords = 0; hist.delete(); end
            nwords++;
            case (mode)
               3'd2: hit = (nwords == 1) && (word == pa || word == pb);
               3'd3: hit = (word == pa || word == pb);
               3'd4: hit = (nwords == 2) && (hist[$] == pa) && (word == pb);
               3'd5: hit = (nwords >= 2) && (hist[$] == pa) && (word == pb);
               3'd6: hit = (nwords == 1) && ((word & pb) == (pa & pb));
               3'd7: hit = ((word & pb) == (pa & pb));
               default: hit = 1'b0;
            endcase
            hist.push_back(word);
            if (hist.size() > 2) void'(hist.pop_front());
         end else if (sof) begin
            nwords = 0; hist.delete();
         end
         mflag = hit | (mflag & ~clr);
      end
   end

   // Cycle-by-cycle comparison against the reference.
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (match !== mflag) begin
            fails++;
            $display("FAIL %s model compare t=%0t: match=%0b expected %0b", cur_req, $time, match, mflag);
         end
      end
   end

   task automatic send(input logic [W-1:0] w, input bit s, input bit c);
      @(negedge clk); word = w; valid = 1'b1; sof = s; clr = c;
   endtask

   task automatic idle();
      @(negedge clk); valid = 1'b0; sof = 1'b0; clr = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk); valid = 1'b0; sof = 1'b0; clr = 1'b1;
      idle();
   endtask

   task automatic expect_flag(input string req, input bit exp);
      checks++;
      if (match !== exp) begin
         fails++;
         $display("FAIL %s directed: match=%0b expected %0b", req, match, exp);
      end
   endtask

   initial begin
      pa = 16'hA5C3; pb = 16'h3C5A;
      repeat (3) @(negedge clk);
      expect_flag("R11", 1'b0);
      rst_n = 1'b1;
      idle();

      // R1: disabled and reserved codes
      cur_req = "R1"; mode = 3'd0;
      send(pa, 1, 0); send(pb, 0, 0); idle(); expect_flag("R1", 1'b0);
      mode = 3'd1;
      send(pb, 1, 0); send(pa, 0, 0); send(pb, 0, 0); idle(); expect_flag("R1", 1'b0);

      // R2: first word only
      cur_req = "R2"; mode = 3'd2;
      send(16'h0001, 1, 0); idle(); send(pa, 0, 0); idle(); expect_flag("R2", 1'b0);
      send(pb, 1, 0); idle(); expect_flag("R2", 1'b1);
      clear_flag(); expect_flag("R9", 1'b0);

      // R3: any word
      cur_req = "R3"; mode = 3'd3;
      send(16'h0001, 1, 0); send(16'h0002, 0, 0); idle(); expect_flag("R3", 1'b0);
      send(pa, 0, 0); idle(); expect_flag("R3", 1'b1);
      repeat (4) idle(); expect_flag("R9", 1'b1);
      clear_flag(); expect_flag("R9", 1'b0);

      // R4: first two words as an ordered pair
      cur_req = "R4"; mode = 3'd4;
      send(pb, 1, 0); send(pa, 0, 0); idle(); expect_flag("R4", 1'b0);
      send(16'h0007, 1, 0); send(pa, 0, 0); send(pb, 0, 0); idle(); expect_flag("R4", 1'b0);
      send(pa, 1, 0); send(16'h0007, 0, 0); send(pb, 0, 0); idle(); expect_flag("R4", 1'b0);
      send(pa, 1, 0); idle(); idle(); send(pb, 0, 0); idle(); expect_flag("R4", 1'b1);
      clear_flag();

      // R8: frame start breaks a pending pair
      cur_req = "R8";
      send(pa, 1, 0); send(pb, 1, 0); idle(); expect_flag("R8", 1'b0);
      mode = 3'd5;
      send(pa, 1, 0); idle(); @(negedge clk); sof = 1'b1; idle();
      send(pb, 0, 0); idle(); expect_flag("R8", 1'b0);

      // R5: pair anywhere in the frame
      cur_req = "R5";
      send(pa, 1, 0); send(16'h0009, 0, 0); send(pb, 0, 0); idle(); expect_flag("R5", 1'b0);
      send(16'h0009, 1, 0); send(16'h0008, 0, 0); send(pa, 0, 0); idle();
      send(pb, 0, 0); idle(); expect_flag("R5", 1'b1);
      clear_flag();

      // R6: masked, first word
      cur_req = "R6"; mode = 3'd6; pa = 16'h1234; pb = 16'h00FF;
      send(16'h0033, 1, 0); send(16'hAB34, 0, 0); idle(); expect_flag("R6", 1'b0);
      send(16'hAB34, 1, 0); idle(); expect_flag("R6", 1'b1);
      clear_flag();

      // R7: masked, any word
      cur_req = "R7"; mode = 3'd7;
      send(16'h1235, 1, 0); send(16'h1230, 0, 0); idle(); expect_flag("R7", 1'b0);
      send(16'hFF34, 0, 0); idle(); expect_flag("R7", 1'b1);

      // R10: clear and match in the same cycle
      cur_req = "R10"; mode = 3'd3; pa = 16'h5555; pb = 16'h6666;
      send(pa, 1, 1); idle(); expect_flag("R10", 1'b1);
      clear_flag(); expect_flag("R9", 1'b0);
      send(16'h0000, 1, 0); send(pb, 0, 1); idle(); expect_flag("R10", 1'b1);
      clear_flag();

      repeat (3) idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule